// File: doc/BRIEF.md
# Fan Tachometer Capture Timer

This block measures how long a fan takes between two tachometer pulses. A 16-bit down-counter advances once per prescaled tick, and an 8-bit divider sets the tick rate. Before each measurement, software writes 0xFFFF into the counter and the capture register, clears the pending flags, and programs a limit value. The usual limit is 0xFFFF minus 0x5000. Software then sets the run bit. The tachometer input passes through a synchronizer. Its first rising edge copies the counter into the capture register and sets the capture flag. If the counter instead steps down onto the limit first, the timeout flag is set. Either event ends the measurement, and the counter then holds its value until software writes the counter again.

A fan that gives two pulses per revolution at R rpm leaves an elapsed count of clk*60 / ((divider+1)*R*2). The elapsed count is 0xFFFF minus the captured value, so software can derive the speed from the capture register. The interrupt line is the OR of the pending flags whose enable bits are set. Registers are reached through a simple byte/halfword bus. Reads are registered and return one cycle after the request.

Register indices (byte address = 2*index): 0 counter, 1 capture, 2 limit, 3 divider, 4 run (bit 0), 5 status (read-only), 6 clear (write-one-to-clear, reads 0), 7 enable. Status and enable hold six flag bits. Bit 0 is the capture flag and bit 4 is the timeout flag. A halfword access uses the full 16 bits, and bus_addr[0] is ignored. A byte write puts wdata[7:0] into the byte lane selected by bus_addr[0], where 1 is the upper byte. A byte read returns the selected byte, zero-extended.

Top module: `tach_capture_timer`

## Requirements
- R1: After reset, the counter and capture registers read 0xFFFF, the status reads 0 and irq is 0.
- R2: A byte write changes only the byte lane chosen by bus_addr[0]. A byte read returns that lane in bits 7:0 with zeros above.
- R3: With run set and divider value D, the counter decrements once every D+1 clocks. The first decrement happens D+1 clocks after the run bit is written.
- R4: A rising edge of tach_in that reaches the core during a measurement does three things: it copies the counter into the capture register, it sets status bit 0, and it freezes the counter, so the counter and capture registers read equal. The input passes through a two-stage synchronizer and an edge register, so an edge driven after clock edge k is captured at edge k+3.
- R5: When a decrement makes the counter equal the limit register with no edge seen, status bit 4 is set and the counter holds the limit value.
- R6: Once a capture or timeout has ended a measurement, later tachometer edges change neither the flags nor the capture register.
- R7: Writing 1s to the clear register clears the matching status bits and leaves the others unchanged.
- R8: irq is 1 exactly one clock after some status bit and its enable bit are both 1, and irq is 0 otherwise.
- R9: With the run bit at 0 the counter holds its value.
- R10: Writing the counter ends the held state and starts a new measurement, so a later timeout or capture sets its flag again.
- R11: A falling edge of tach_in, or a level that was already high when the measurement began, does not cause a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_half | input | 1 | 1 = halfword access, 0 = byte access |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| tach_in | input | 1 | Asynchronous tachometer pulse input |
| irq | output | 1 | Interrupt, OR of the enabled pending flags |

## Verification
Captures are taken at two divider settings (0 and 3) with edges placed at different delays. Comparing the exact captured value against the floor formula shows both the tick spacing and the three-cycle synchronizer latency. A short limit at divider 1 triggers a timeout. A later rising edge then shows that only the first event counts, and rewriting the counter shows that it starts a fresh measurement. A stopped counter, an input that is already high, and a falling edge all leave the capture state alone. Each enable pattern is driven against a set flag, which separates the gating from the flags themselves.

// File: rtl/tach_pkg.sv
package tach_pkg;
  localparam int BUS_W = 16;

  typedef enum logic [3:0] {
    IX_COUNT = 4'd0,
    IX_CAPT  = 4'd1,
    IX_LIMIT = 4'd2,
    IX_DIV   = 4'd3,
    IX_RUN   = 4'd4,
    IX_STAT  = 4'd5,
    IX_CLR   = 4'd6,
    IX_IEN   = 4'd7
  } reg_ix_e;

  localparam int FLAG_CAPT = 0;
  localparam int FLAG_TMO  = 4;

  function automatic logic [BUS_W-1:0] lane_merge(
    input logic [BUS_W-1:0] old_v,
    input logic [BUS_W-1:0] wd,
    input logic             half,
    input logic             upper
  );
    if (half)       return wd;
    else if (upper) return {wd[7:0], old_v[7:0]};
    else            return {old_v[15:8], wd[7:0]};
  endfunction
endpackage

// File: rtl/tach_sync.sv
module tach_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 1'b0;
        else     chain[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 1'b0;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/tach_prescale.sv
module tach_prescale #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PRE_W-1:0] div,
  output logic             tick
);
  logic [PRE_W-1:0] pcnt;

  assign tick = run && (pcnt == div);

  always_ff @(posedge clk) begin
    if (rst)       pcnt <= '0;
    else if (!run) pcnt <= '0;
    else if (tick) pcnt <= '0;
    else           pcnt <= pcnt + 1'b1;
  end
endmodule

// File: rtl/tach_core.sv
module tach_core
  import tach_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int FLAG_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              tick,
  input  logic              rise,
  input  logic [CNT_W-1:0]  limit,
  input  logic              cnt_wr,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic              cap_wr,
  input  logic [CNT_W-1:0]  cap_wdata,
  input  logic [FLAG_W-1:0] clr_mask,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  cap,
  output logic [FLAG_W-1:0] flags,
  output logic              done
);
  logic             armed;
  logic             hit_cap;
  logic             hit_tmo;
  logic [CNT_W-1:0] cnt_dec;
  logic [FLAG_W-1:0] flag_set;

  assign armed   = run && !done && !cnt_wr;
  assign cnt_dec = cnt - 1'b1;
  assign hit_cap = armed && rise;
  assign hit_tmo = armed && !rise && tick && (cnt_dec == limit);

  always_comb begin
    flag_set = '0;
    flag_set[FLAG_CAPT] = hit_cap;
    flag_set[FLAG_TMO]  = hit_tmo;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '1;
      cap   <= '1;
      flags <= '0;
      done  <= 1'b0;
    end else begin
      flags <= (flags & ~clr_mask) | flag_set;
      if (cnt_wr) begin
        cnt  <= cnt_wdata;
        done <= 1'b0;
      end else if (hit_cap) begin
        done <= 1'b1;
      end else if (armed && tick) begin
        cnt <= cnt_dec;
        if (hit_tmo) done <= 1'b1;
      end
      if (cap_wr)       cap <= cap_wdata;
      else if (hit_cap) cap <= cnt;
    end
  end
endmodule

// File: rtl/tach_capture_timer.sv
module tach_capture_timer
  import tach_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PRE_W       = 8,
  parameter int FLAG_W      = 6,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_half,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic              tach_in,
  output logic              irq
);
  localparam int IX_W = ADDR_W - 1;

  logic [IX_W-1:0]   ix;
  logic              upper;
  logic [BUS_W-1:0]  rd_word;
  logic [BUS_W-1:0]  wr_word;
  logic [CNT_W-1:0]  limit_q;
  logic [PRE_W-1:0]  div_q;
  logic              run_q;
  logic [FLAG_W-1:0] ien_q;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  cap;
  logic [FLAG_W-1:0] flags;
  logic              done;
  logic              tick;
  logic              rise;
  logic              cnt_wr;
  logic              cap_wr;
  logic [FLAG_W-1:0] clr_mask;

  assign ix    = bus_addr[ADDR_W-1:1];
  assign upper = bus_addr[0];

  always_comb begin
    rd_word = '0;
    case (ix)
      IX_W'(IX_COUNT): rd_word = BUS_W'(cnt);
      IX_W'(IX_CAPT):  rd_word = BUS_W'(cap);
      IX_W'(IX_LIMIT): rd_word = BUS_W'(limit_q);
      IX_W'(IX_DIV):   rd_word = BUS_W'(div_q);
      IX_W'(IX_RUN):   rd_word = BUS_W'(run_q);
      IX_W'(IX_STAT):  rd_word = BUS_W'(flags);
      IX_W'(IX_IEN):   rd_word = BUS_W'(ien_q);
      default:         rd_word = '0;
    endcase
  end

  assign wr_word  = lane_merge(rd_word, bus_wdata, bus_half, upper);
  assign cnt_wr   = bus_wr && (ix == IX_W'(IX_COUNT));
  assign cap_wr   = bus_wr && (ix == IX_W'(IX_CAPT));
  assign clr_mask = (bus_wr && (ix == IX_W'(IX_CLR))) ?
                    FLAG_W'(lane_merge('0, bus_wdata, bus_half, upper)) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      limit_q <= '0;
      div_q   <= '0;
      run_q   <= 1'b0;
      ien_q   <= '0;
    end else if (bus_wr) begin
      case (ix)
        IX_W'(IX_LIMIT): limit_q <= CNT_W'(wr_word);
        IX_W'(IX_DIV):   div_q   <= PRE_W'(wr_word);
        IX_W'(IX_RUN):   run_q   <= wr_word[0];
        IX_W'(IX_IEN):   ien_q   <= FLAG_W'(wr_word);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      irq        <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) begin
        if (bus_half)   bus_rdata <= rd_word;
        else if (upper) bus_rdata <= {8'h00, rd_word[15:8]};
        else            bus_rdata <= {8'h00, rd_word[7:0]};
      end
      irq <= |(flags & ien_q);
    end
  end

  tach_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (tach_in),
    .rise(rise)
  );

  tach_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk (clk),
    .rst (rst),
    .run (run_q),
    .div (div_q),
    .tick(tick)
  );

  tach_core #(.CNT_W(CNT_W), .FLAG_W(FLAG_W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .run      (run_q),
    .tick     (tick),
    .rise     (rise),
    .limit    (limit_q),
    .cnt_wr   (cnt_wr),
    .cnt_wdata(CNT_W'(wr_word)),
    .cap_wr   (cap_wr),
    .cap_wdata(CNT_W'(wr_word)),
    .clr_mask (clr_mask),
    .cnt      (cnt),
    .cap      (cap),
    .flags    (flags),
    .done     (done)
  );
endmodule

// File: rtl/tach_capture_timer_chk.sv
module tach_capture_timer_chk #(
  parameter int CNT_W  = 16,
  parameter int FLAG_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              irq,
  input logic              run_q,
  input logic              done,
  input logic              cnt_wr,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  cap,
  input logic [CNT_W-1:0]  limit_q,
  input logic [FLAG_W-1:0] flags,
  input logic [FLAG_W-1:0] ien_q
);
  a_r4_capture_copies_count: assert property (@(posedge clk) disable iff (rst)
    $rose(flags[0]) |-> (cap == cnt));

  a_r5_timeout_at_limit: assert property (@(posedge clk) disable iff (rst)
    $rose(flags[4]) |-> (cnt == limit_q));

  a_r6_held_after_event: assert property (@(posedge clk) disable iff (rst)
    (done && !cnt_wr) |=> $stable(cnt));

  a_r9_stopped_holds: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !cnt_wr) |=> $stable(cnt));

  a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    ($past(flags & ien_q) == '0) |-> !irq);
endmodule

bind tach_capture_timer tach_capture_timer_chk #(.CNT_W(CNT_W), .FLAG_W(FLAG_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .irq    (irq),
  .run_q  (run_q),
  .done   (done),
  .cnt_wr (cnt_wr),
  .cnt    (cnt),
  .cap    (cap),
  .limit_q(limit_q),
  .flags  (flags),
  .ien_q  (ien_q)
);

// File: tb/tach_capture_timer_tb.sv
module tach_capture_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic        bus_half = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_rvalid;
  logic        tach_in = 1'b0;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [15:0] exp_q[$];
  string       req_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tach_capture_timer u_dut (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_half  (bus_half),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_rvalid(bus_rvalid),
    .tach_in   (tach_in),
    .irq       (irq)
  );

  // scoreboard monitor
  always @(negedge clk) begin
    if (bus_rvalid) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL unexpected read data: got %h expected none", bus_rdata);
      end else begin
        logic [15:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        if (bus_rdata !== e) begin
          bad++;
          $display("FAIL %s: got %h expected %h", r, bus_rdata, e);
        end
      end
    end
  end

  task automatic wr(input int idx, input logic [15:0] d,
                    input logic half = 1'b1, input logic up = 1'b0);
    @(negedge clk);
    bus_wr = 1'b1; bus_half = half; bus_addr = 5'(idx*2 + int'(up)); bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; bus_half = 1'b1;
  endtask

  task automatic rd_exp(input int idx, input logic [15:0] e, input string r,
                        input logic half = 1'b1, input logic up = 1'b0);
    @(negedge clk);
    exp_q.push_back(e);
    req_q.push_back(r);
    bus_rd = 1'b1; bus_half = half; bus_addr = 5'(idx*2 + int'(up));
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0; bus_half = 1'b1;
  endtask

  task automatic chk_irq(input logic e, input string r);
    @(negedge clk);
    total++;
    if (irq !== e) begin
      bad++;
      $display("FAIL %s irq: got %b expected %b", r, irq, e);
    end
  endtask

  task automatic arm(input logic [15:0] divv, input logic [15:0] lim);
    wr(4, 16'h0000);
    wr(3, divv);
    wr(2, lim);
    wr(0, 16'hFFFF);
    wr(1, 16'hFFFF);
    wr(6, 16'h003F);
  endtask

  task automatic capture_run(input int n, input int d, input string r);
    logic [15:0] e;
    e = 16'hFFFF - 16'((n + 2) / (d + 1));
    wr(4, 16'h0001);
    repeat (n) @(negedge clk);
    tach_in = 1'b1;
    repeat (10) @(negedge clk);
    rd_exp(1, e, r);
    rd_exp(0, e, r);
    rd_exp(5, 16'h0001, r);
    tach_in = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd_exp(0, 16'hFFFF, "R1 counter");
    rd_exp(1, 16'hFFFF, "R1 capture");
    rd_exp(5, 16'h0000, "R1 status");
    chk_irq(1'b0, "R1");

    // R2 byte lanes
    wr(2, 16'h00AB);
    wr(2, 16'h0034, 1'b0, 1'b0);
    wr(2, 16'h0012, 1'b0, 1'b1);
    rd_exp(2, 16'h1234, "R2 halfword after byte writes");
    rd_exp(2, 16'h0012, "R2 byte read upper", 1'b0, 1'b1);

    // R3 R4 captures at two divider settings
    wr(7, 16'h0001);
    arm(16'd0, 16'h0000);
    capture_run(10, 0, "R3 R4 div0");
    chk_irq(1'b1, "R8 capture enabled");
    // R7 clear capture flag
    wr(6, 16'h0001);
    rd_exp(5, 16'h0000, "R7 clear");
    chk_irq(1'b0, "R7 irq after clear");
    arm(16'd3, 16'h0000);
    capture_run(20, 3, "R3 R4 div3");

    // R5 timeout
    wr(7, 16'h0010);
    arm(16'd1, 16'hFFF7);
    wr(4, 16'h0001);
    repeat (40) @(negedge clk);
    rd_exp(5, 16'h0010, "R5 timeout flag");
    rd_exp(0, 16'hFFF7, "R5 counter at limit");
    chk_irq(1'b1, "R8 timeout enabled");

    // R6 later edge ignored
    tach_in = 1'b1;
    repeat (10) @(negedge clk);
    rd_exp(5, 16'h0010, "R6 status unchanged");
    rd_exp(1, 16'hFFFF, "R6 capture unchanged");
    tach_in = 1'b0;
    repeat (6) @(negedge clk);

    // R8 gating
    wr(7, 16'h0000);
    repeat (2) @(negedge clk);
    chk_irq(1'b0, "R8 none enabled");
    wr(7, 16'h0001);
    repeat (2) @(negedge clk);
    chk_irq(1'b0, "R8 other bit enabled");
    wr(7, 16'h0010);
    repeat (2) @(negedge clk);
    chk_irq(1'b1, "R8 matching bit enabled");

    // R10 rearm by counter write
    wr(6, 16'h003F);
    rd_exp(5, 16'h0000, "R10 cleared before rearm");
    wr(0, 16'hFFFF);
    repeat (40) @(negedge clk);
    rd_exp(5, 16'h0010, "R10 timeout again");
    rd_exp(0, 16'hFFF7, "R10 counter");

    // R9 stopped
    wr(4, 16'h0000);
    wr(0, 16'h8000);
    repeat (20) @(negedge clk);
    rd_exp(0, 16'h8000, "R9 counter held");

    // R11 pre-existing level and falling edge
    tach_in = 1'b1;
    repeat (6) @(negedge clk);
    arm(16'd0, 16'h0000);
    wr(4, 16'h0001);
    repeat (8) @(negedge clk);
    tach_in = 1'b0;
    repeat (10) @(negedge clk);
    rd_exp(5, 16'h0000, "R11 no capture");
    rd_exp(1, 16'hFFFF, "R11 capture untouched");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule